// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside the arithmetic unit of an 8-bit accumulator processor. It computes the 8-bit result of one operation from two operands, an operation code and an incoming carry. It also works out five condition flags from that operation and holds them in a register: sign, zero, auxiliary (nibble) carry, even parity and carry. The operation set covers add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, increment and decrement. Each operation class changes only the flags that belong to it. A per-flag enable lets the instruction sequencer narrow the update further.

The result and an accumulator write strobe are combinational. The held flags change on the clock edge that samples a valid operation. The whole flag byte can also be written in one step, as when a saved status word is restored from memory. The packed byte has a fixed layout, and its three spare positions read back as constants.

Top module: `alu_flag_unit`

## Requirements
- R1: The flag byte `flags` is laid out as bit 7 sign, bit 6 zero, bit 4 auxiliary carry, bit 2 parity, bit 0 carry. Bits 5 and 3 always read 0 and bit 1 always reads 1. Each single-flag output equals its bit in the byte.
- R2: While reset is asserted and after it is released, `flags` reads 8'h02 until the first update.
- R3: `result` is the 8-bit modulo result for each operation. Codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 compare (A minus B), 8 increment A, 9 decrement A. `acc_we` is high for valid codes 0–6, 8 and 9, and low for compare.
- R4: After an updating operation, sign equals result bit 7, zero is set when the result is 8'h00, and parity is set when the result has an even number of ones.
- R5: Carry is set on a carry out of bit 7 for add, add with carry and increment's class siblings. For subtract, subtract with borrow and compare it is set on a borrow, meaning A < B + carry-in.
- R6: Auxiliary carry is the carry from bit 3 into bit 4 for additions and increment. For subtractions, compare and decrement it is the borrow into the low nibble.
- R7: Increment and decrement leave the carry flag unchanged.
- R8: Logical operations clear carry. AND sets auxiliary carry; OR and XOR clear it.
- R9: `upd_en` bit 4 enables sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity and bit 0 carry. A flag whose enable is low keeps its value.
- R10: With `op_valid` low and no load, no flag changes.
- R11: `flag_ld` writes bits 7, 6, 4, 2 and 0 of `flag_ld_data` into the flags on the next edge, overriding any operation in the same cycle.
- R12: Codes 10 to 15 change no flag and hold `acc_we` low. Their `result` is operand A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Operand A (accumulator) |
| opb | input | 8 | Operand B |
| cin | input | 1 | Incoming carry/borrow for the with-carry forms |
| upd_en | input | 5 | Per-flag update enables (S,Z,AC,P,CY from bit 4 down) |
| flag_ld | input | 1 | Load the whole flag byte |
| flag_ld_data | input | 8 | Flag byte to load |
| result | output | 8 | Operation result |
| acc_we | output | 1 | Result is to be written to the accumulator |
| flags | output | 8 | Packed flag byte |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Auxiliary carry flag |
| flag_p | output | 1 | Parity flag |
| flag_cy | output | 1 | Carry flag |

## Verification
`result` and `acc_we` are combinational, so they are due in the same cycle the inputs are presented. The bench drives inputs on the falling edge and samples these two outputs shortly after, before the next rising edge. The flags pass through one register and are due one rising edge after the operation or load is presented. The bench reads them at the following falling edge, by which time the next stimulus has not yet been clocked. Reset release goes through a two-stage synchronizer, so checks begin only after three rising edges with reset high.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBB = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_CMP = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8;
  localparam logic [3:0] OP_DEC = 4'd9;

  localparam int NFLAG = 5;
  localparam int FI_CY = 0;
  localparam int FI_P  = 1;
  localparam int FI_AC = 2;
  localparam int FI_Z  = 3;
  localparam int FI_S  = 4;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam logic [7:0] FB_CONST = 8'h02;

  function automatic logic op_is_defined(input logic [3:0] op);
    return op <= OP_DEC;
  endfunction
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic          aux
);
  import alu_flag_pkg::*;
  localparam int HW = DW / 2;

  logic          subtract;
  logic          arith;
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   sum_full;
  logic [HW:0]   sum_half;

  always_comb begin
    subtract = 1'b0;
    arith    = 1'b1;
    b_eff    = b;
    c_eff    = 1'b0;
    unique case (op)
      OP_ADD: begin b_eff = b; c_eff = 1'b0; end
      OP_ADC: begin b_eff = b; c_eff = cin;  end
      OP_SUB, OP_CMP: begin subtract = 1'b1; b_eff = ~b; c_eff = 1'b1; end
      OP_SBB: begin subtract = 1'b1; b_eff = ~b; c_eff = ~cin; end
      OP_INC: begin b_eff = '0; c_eff = 1'b1; end
      OP_DEC: begin subtract = 1'b1; b_eff = ~DW'(1); c_eff = 1'b1; end
      default: arith = 1'b0;
    endcase
  end

  assign sum_full = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
  assign sum_half = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};

  always_comb begin
    res   = a;
    carry = 1'b0;
    aux   = 1'b0;
    if (arith) begin
      res   = sum_full[DW-1:0];
      carry = subtract ? ~sum_full[DW] : sum_full[DW];
      aux   = subtract ? ~sum_half[HW] : sum_half[HW];
    end else begin
      unique case (op)
        OP_AND:  begin res = a & b; aux = 1'b1; end
        OP_OR:   res = a | b;
        OP_XOR:  res = a ^ b;
        default: res = a;
      endcase
    end
  end
endmodule

// File: rtl/flag_eval.sv
module flag_eval #(
  parameter int DW = 8
) (
  input  logic [3:0]                     op,
  input  logic [DW-1:0]                  res,
  input  logic                           carry,
  input  logic                           aux,
  output logic [alu_flag_pkg::NFLAG-1:0] cand,
  output logic [alu_flag_pkg::NFLAG-1:0] class_mask
);
  import alu_flag_pkg::*;

  always_comb begin
    cand        = '0;
    cand[FI_S]  = res[DW-1];
    cand[FI_Z]  = (res == '0);
    cand[FI_P]  = ~^res;
    cand[FI_AC] = aux;
    cand[FI_CY] = carry;
  end

  always_comb begin
    class_mask = '0;
    if (op_is_defined(op)) begin
      class_mask = '1;
      if (op == OP_INC || op == OP_DEC) class_mask[FI_CY] = 1'b0;
    end
  end
endmodule

// File: rtl/flag_store.sv
module flag_store (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld,
  input  logic [alu_flag_pkg::NFLAG-1:0] ld_val,
  input  logic [alu_flag_pkg::NFLAG-1:0] en,
  input  logic [alu_flag_pkg::NFLAG-1:0] cand,
  output logic [alu_flag_pkg::NFLAG-1:0] q,
  output logic [7:0]                     byte_out
);
  import alu_flag_pkg::*;

  logic [NFLAG-1:0] q_nxt;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_comb begin
      if (ld)         q_nxt[i] = ld_val[i];
      else if (en[i]) q_nxt[i] = cand[i];
      else            q_nxt[i] = q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_nxt[i];
    end

    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !en[i]) |=> (q[i] == $past(q[i])));
  end

  always_comb begin
    byte_out        = FB_CONST;
    byte_out[FB_S]  = q[FI_S];
    byte_out[FB_Z]  = q[FI_Z];
    byte_out[FB_AC] = q[FI_AC];
    byte_out[FB_P]  = q[FI_P];
    byte_out[FB_CY] = q[FI_CY];
  end

  p_spare_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_out[5] == 1'b0) && (byte_out[3] == 1'b0) && (byte_out[1] == 1'b1));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          cin,
  input  logic [4:0]    upd_en,
  input  logic          flag_ld,
  input  logic [7:0]    flag_ld_data,
  output logic [DW-1:0] result,
  output logic          acc_we,
  output logic [7:0]    flags,
  output logic          flag_s,
  output logic          flag_z,
  output logic          flag_ac,
  output logic          flag_p,
  output logic          flag_cy
);
  import alu_flag_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_sync_n;
  logic             dp_carry;
  logic             dp_aux;
  logic [NFLAG-1:0] cand;
  logic [NFLAG-1:0] class_mask;
  logic [NFLAG-1:0] flag_en;
  logic [NFLAG-1:0] ld_val;
  logic [NFLAG-1:0] flag_q;
  logic             unused_ld_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  alu_datapath #(.DW(DW)) u_dp (
    .op    (op_sel),
    .a     (opa),
    .b     (opb),
    .cin   (cin),
    .res   (result),
    .carry (dp_carry),
    .aux   (dp_aux)
  );

  flag_eval #(.DW(DW)) u_eval (
    .op         (op_sel),
    .res        (result),
    .carry      (dp_carry),
    .aux        (dp_aux),
    .cand       (cand),
    .class_mask (class_mask)
  );

  always_comb begin
    flag_en = {NFLAG{op_valid}} & upd_en & class_mask;
    ld_val  = '0;
    ld_val[FI_S]  = flag_ld_data[FB_S];
    ld_val[FI_Z]  = flag_ld_data[FB_Z];
    ld_val[FI_AC] = flag_ld_data[FB_AC];
    ld_val[FI_P]  = flag_ld_data[FB_P];
    ld_val[FI_CY] = flag_ld_data[FB_CY];
  end
  assign unused_ld_bits = ^{flag_ld_data[5], flag_ld_data[3], flag_ld_data[1]};

  flag_store u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ld       (flag_ld),
    .ld_val   (ld_val),
    .en       (flag_en),
    .cand     (cand),
    .q        (flag_q),
    .byte_out (flags)
  );

  assign acc_we  = op_valid && op_is_defined(op_sel) && (op_sel != OP_CMP);
  assign flag_s  = flag_q[FI_S];
  assign flag_z  = flag_q[FI_Z];
  assign flag_ac = flag_q[FI_AC];
  assign flag_p  = flag_q[FI_P];
  assign flag_cy = flag_q[FI_CY];

  p_incdec_keeps_cy_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !flag_ld && (op_sel == OP_INC || op_sel == OP_DEC))
      |=> (flag_cy == $past(flag_cy)));

  p_idle_no_change_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!op_valid && !flag_ld) |=> (flags == $past(flags)));

  p_undef_quiet_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel > OP_DEC && !flag_ld) |=> (flags == $past(flags)));

  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_sel == OP_CMP) |-> !acc_we);

  p_zero_result_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && upd_en[FI_Z] && op_is_defined(op_sel) && !flag_ld && result == '0)
      |=> flag_z);
endmodule

// File: tb/tb_alu_flag_unit.sv
module tb_alu_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_sel;
  logic [7:0] opa, opb;
  logic       cin;
  logic [4:0] upd_en;
  logic       flag_ld;
  logic [7:0] flag_ld_data;
  logic [7:0] result;
  logic       acc_we;
  logic [7:0] flags;
  logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .cin(cin), .upd_en(upd_en), .flag_ld(flag_ld),
    .flag_ld_data(flag_ld_data), .result(result), .acc_we(acc_we),
    .flags(flags), .flag_s(flag_s), .flag_z(flag_z), .flag_ac(flag_ac),
    .flag_p(flag_p), .flag_cy(flag_cy)
  );

  // {op, a, b, cin, expected result, expected acc_we, expected flags}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {4'd0, 8'h3A, 8'h86, 1'b0, 8'hC0, 1'b1, 8'h96},  // R3 R4 R6 add half carry
    {4'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 8'h57},  // R5 carry out, zero
    {4'd1, 8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 8'h02},  // R3 add with carry, odd parity
    {4'd2, 8'h50, 8'h20, 1'b0, 8'h30, 1'b1, 8'h06},  // R5 no borrow
    {4'd2, 8'h20, 8'h21, 1'b0, 8'hFF, 1'b1, 8'h97},  // R5 R6 borrow both
    {4'd3, 8'h40, 8'h3F, 1'b1, 8'h00, 1'b1, 8'h56},  // R5 R6 sub with borrow
    {4'd4, 8'hF0, 8'h3C, 1'b0, 8'h30, 1'b1, 8'h16},  // R8 AND sets AC
    {4'd5, 8'h81, 8'h02, 1'b0, 8'h83, 1'b1, 8'h82},  // R8 OR clears AC
    {4'd6, 8'h5A, 8'h5A, 1'b0, 8'h00, 1'b1, 8'h46},  // R8 XOR
    {4'd7, 8'h10, 8'h20, 1'b0, 8'hF0, 1'b0, 8'h87},  // R3 compare no write
    {4'd8, 8'h7F, 8'h00, 1'b0, 8'h80, 1'b1, 8'h93},  // R7 inc keeps CY=1
    {4'd9, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 8'h97},  // R7 dec keeps CY=1
    {4'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h46},  // R5 clears CY
    {4'd9, 8'h10, 8'h00, 1'b0, 8'h0F, 1'b1, 8'h16},  // R6 dec nibble borrow, R7 CY=0
    {4'd12, 8'h55, 8'h00, 1'b0, 8'h55, 1'b0, 8'h16}  // R12 undefined code
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_layout();
    check8("R1", {flags[5], flags[3], flags[1]}, 8'h01);
    check8("R1", {3'b0, flag_s, flag_z, flag_ac, flag_p, flag_cy},
           {3'b0, flags[7], flags[6], flags[4], flags[2], flags[0]});
  endtask

  task automatic drive(input logic v, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic c, input logic [4:0] en,
                       input logic ld, input logic [7:0] ldd);
    op_valid = v; op_sel = op; opa = a; opb = b; cin = c;
    upd_en = en; flag_ld = ld; flag_ld_data = ldd;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    drive(1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 5'h1F, 1'b0, 8'h00);
  endtask

  initial begin
    drive(1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 5'h1F, 1'b0, 8'h00);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 check8("R2", flags, 8'h02);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R2", flags, 8'h02);
    check_layout();

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][37:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17],
            5'h1F, 1'b0, 8'h00);
      #2;
      check8("R3", result, VEC[i][16:9]);
      check8("R3/R12 acc_we", {7'b0, acc_we}, {7'b0, VEC[i][8]});
      @(posedge clk);
      @(negedge clk);
      check8("R4-R8,R12 flags", flags, VEC[i][7:0]);
      check_layout();
    end

    // R11: load overrides a simultaneous operation; spare bits forced
    drive(1'b1, 4'd0, 8'h00, 8'h00, 1'b0, 5'h1F, 1'b1, 8'hFF);
    @(posedge clk); @(negedge clk);
    check8("R11", flags, 8'hD7);
    check_layout();
    drive(1'b0, 4'd0, 8'h00, 8'h00, 1'b0, 5'h1F, 1'b1, 8'h00);
    @(posedge clk); @(negedge clk);
    check8("R11", flags, 8'h02);

    // R9: only zero enabled (upd_en bit 3)
    drive(1'b1, 4'd0, 8'hFF, 8'h01, 1'b0, 5'b01000, 1'b0, 8'h00);
    @(posedge clk); @(negedge clk);
    check8("R9", flags, 8'h42);
    // R9: only carry enabled (bit 0), result 0x00 would set Z, P, AC too
    drive(1'b1, 4'd0, 8'hFF, 8'h01, 1'b0, 5'b00001, 1'b0, 8'h00);
    @(posedge clk); @(negedge clk);
    check8("R9", flags, 8'h43);

    // R10: op_valid low, operation that would change flags
    drive(1'b0, 4'd2, 8'h00, 8'h01, 1'b0, 5'h1F, 1'b0, 8'h00);
    #2 check8("R10 acc_we", {7'b0, acc_we}, 8'h00);
    @(posedge clk); @(negedge clk);
    check8("R10", flags, 8'h43);

    // R12: another undefined code with all enables
    drive(1'b1, 4'd15, 8'hA5, 8'h00, 1'b1, 5'h1F, 1'b0, 8'h00);
    #2 check8("R12 result", result, 8'hA5);
    @(posedge clk); @(negedge clk);
    check8("R12", flags, 8'h43);

    // R2: asynchronous reset mid-run
    idle_cycle();
    #1 rst_n = 1'b0;
    #1 check8("R2 async", flags, 8'h02);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check8("R2", flags, 8'h02);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule